// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block derives the serial clock line level for an I2C master from the fast system clock. A programmable prescaler first slows the system clock into a stream of single-cycle clock-enable pulses. Two phase counters then measure out the low and the high half of each SCL period in those pulses. Each half lasts its programmed count plus a small fixed offset. The offset depends on the prescaler setting, or it is a constant 6 in a build-time variant.

The protocol engine watches `scl_level` and uses `scl_ce` to pace its own state changes. Software programs the three divider fields while the controller is held in its module reset (`enable` low). The block copies them into internal holding registers only during that time. Once `enable` is high and the engine raises `run`, clocks are produced. Every period starts with the low half. Dropping either control input releases SCL high on the next clock edge. The next start then begins a fresh, full low half.

Top module: `scl_clk_div`

## Requirements
- R1: While `enable` or `run` is low, `scl_level` is 1 and `scl_ce` is 0 from the clock edge after that input was sampled low.
- R2: The divider fields `psc_val`, `low_val` and `high_val` are copied at each clock edge where `enable` is low. Changes made to them while `enable` is high have no effect on the waveform until `enable` has been low again.
- R3: While clocks run, `scl_ce` pulses for one cycle every `psc_val + 1` system cycles. The first pulse comes `psc_val + 1` cycles after SCL first drops.
- R4: With the default build, the phase offset d is 7 for a prescaler value of 0, 6 for a value of 1, and 5 for any value of 2 or more.
- R5: With `USE_FIXED_OFFSET` set to 1, the offset d is 6 for every prescaler value.
- R6: After a start, SCL is low for `(low_val + d) * (psc_val + 1)` cycles and then high for `(high_val + d) * (psc_val + 1)` cycles. This low-then-high pattern repeats, so the period is `(psc_val+1) * (low_val + high_val + 2d)`.
- R7: If the captured high count is 0, no clock is produced: `scl_level` stays 1 and `scl_ce` stays 0 even with `enable` and `run` high.
- R8: Stopping and restarting clears the prescaler and phase state. After a restart, the first low half has its full length, whatever point the previous run had reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (input) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module-out-of-reset bit; low allows divider fields to be captured |
| run | input | 1 | Request from the protocol engine to produce clocks |
| psc_val | input | 16 | Prescaler divide value minus one |
| low_val | input | 16 | Low-half count, before the offset is added |
| high_val | input | 16 | High-half count, before the offset is added; 0 disables SCL |
| scl_level | output | 1 | SCL level for the protocol engine (1 = released) |
| scl_ce | output | 1 | One-cycle prescaled clock-enable pulse |

## Verification
The assertions rely on reset being applied at the start. They also rely on the divider holding registers changing only on an edge where `enable` is low. Because clock generation starts and stops only through a registered copy of `enable`, the prescaler limit and phase lengths they compare against are frozen whenever counting is under way. The stimulus keeps to this. It changes the divider fields with `enable` low and waits several edges before raising it. The one exception is the R2 test, which deliberately changes the fields while enabled to show that they are ignored. Starts and stops are driven on the falling edge, and at least two idle edges are left before any restart.

// File: rtl/scl_div_pkg.sv
// Package: shared phase encoding and offset rule for the SCL divider.
// Assumes: callers pass prescaler comparisons already decoded.
package scl_div_pkg;

    // SCL phase encoding: value equals the driven line level
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } scl_phase_e;

    // Offset added to each phase count when the prescaler is used as-is
    localparam logic [2:0] OFS_PSC0  = 3'd7;
    localparam logic [2:0] OFS_PSC1  = 3'd6;
    localparam logic [2:0] OFS_WIDE  = 3'd5;
    localparam logic [2:0] OFS_FIXED = 3'd6;

    // Pick the offset from the decoded prescaler value
    function automatic logic [2:0] scaled_offset(input logic is_zero, input logic is_one);
        if (is_zero)     return OFS_PSC0;
        else if (is_one) return OFS_PSC1;
        else             return OFS_WIDE;
    endfunction

endpackage

// File: rtl/scl_cfg_hold.sv
// Module: scl_cfg_hold
// Captures the divider fields while the controller is held in reset and
// turns them into phase lengths (count + offset) for the phase sequencer.
// Assumes: fields are meaningful only once enable has been low for an edge.
module scl_cfg_hold
    import scl_div_pkg::*;
#(
    parameter int CNT_W            = 16,
    parameter bit USE_FIXED_OFFSET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] psc_i,
    input  logic [CNT_W-1:0] low_i,
    input  logic [CNT_W-1:0] high_i,
    output logic [CNT_W-1:0] psc_o,
    output logic [CNT_W:0]   low_len_o,
    output logic [CNT_W:0]   high_len_o,
    output logic             gen_ok_o
);
    localparam int LEN_W = CNT_W + 1;

    logic [CNT_W-1:0] psc_q;
    logic [CNT_W-1:0] low_q;
    logic [CNT_W-1:0] high_q;
    logic [2:0]       ofs_w;

    // Holding registers follow the inputs only while in module reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q  <= '0;
            low_q  <= '0;
            high_q <= '0;
        end else if (!enable_i) begin
            psc_q  <= psc_i;
            low_q  <= low_i;
            high_q <= high_i;
        end
    end

    // Offset selection: constant variant or prescaler-dependent variant
    generate
        if (USE_FIXED_OFFSET) begin : g_fixed_ofs
            assign ofs_w = OFS_FIXED;
        end else begin : g_scaled_ofs
            always_comb ofs_w = scaled_offset(psc_q == '0, psc_q == CNT_W'(1));
        end
    endgenerate

    // Phase lengths in prescaled ticks
    always_comb begin
        low_len_o  = {1'b0, low_q}  + LEN_W'(ofs_w);
        high_len_o = {1'b0, high_q} + LEN_W'(ofs_w);
    end

    assign psc_o    = psc_q;
    assign gen_ok_o = (high_q != '0);

endmodule

// File: rtl/scl_prescale.sv
// Module: scl_prescale
// Divides the system clock by (limit + 1), giving a one-cycle tick.
// Assumes: limit is frozen while run_i is high.
module scl_prescale #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] lim_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == lim_i);

    // Free-running count 0..limit, cleared whenever generation stops
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run_i)       cnt_q <= '0;
        else if (cnt_q == lim_i) cnt_q <= '0;
        else                   cnt_q <= cnt_q + CNT_W'(1);
    end

    // R3
    psc_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q <= lim_i));

    // R3
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && (lim_i != '0)) |=> !tick_o);

endmodule

// File: rtl/scl_phase_seq.sv
// Module: scl_phase_seq
// Counts prescaled ticks through a low half then a high half, repeating.
// Assumes: lengths are at least 1 and frozen while run_i is high.
module scl_phase_seq
    import scl_div_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run_i,
    input  logic           tick_i,
    input  logic [CNT_W:0] low_len_i,
    input  logic [CNT_W:0] high_len_i,
    output logic           phase_o
);
    localparam int LEN_W = CNT_W + 1;

    scl_phase_e     phase_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cur_len;

    // Length of the phase currently being measured
    always_comb cur_len = (phase_q == PH_HIGH) ? high_len_i : low_len_i;

    // Tick counter with phase swap at the end of each half
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
        end else if (tick_i) begin
            if (cnt_q == cur_len - LEN_W'(1)) begin
                cnt_q   <= '0;
                phase_q <= (phase_q == PH_HIGH) ? PH_LOW : PH_HIGH;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end

    assign phase_o = phase_q;

    // R6
    phase_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (cnt_q < cur_len));

    // R6
    phase_flip_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && (phase_q != $past(phase_q))) |-> $past(tick_i));

endmodule

// File: rtl/scl_clk_div.sv
// Module: scl_clk_div (top)
// SCL timing generator: holding registers, prescaler and phase sequencer.
// SCL is released high whenever generation is not running.
// Assumes: synchronous active-low reset applied before use.
module scl_clk_div #(
    parameter int CNT_W            = 16,
    parameter bit USE_FIXED_OFFSET = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run,
    input  logic [CNT_W-1:0] psc_val,
    input  logic [CNT_W-1:0] low_val,
    input  logic [CNT_W-1:0] high_val,
    output logic             scl_level,
    output logic             scl_ce
);
    logic [CNT_W-1:0] psc_q;
    logic [CNT_W:0]   low_len;
    logic [CNT_W:0]   high_len;
    logic             gen_ok;
    logic             running_q;
    logic             tick;
    logic             phase;

    scl_cfg_hold #(.CNT_W(CNT_W), .USE_FIXED_OFFSET(USE_FIXED_OFFSET)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (enable),
        .psc_i      (psc_val),
        .low_i      (low_val),
        .high_i     (high_val),
        .psc_o      (psc_q),
        .low_len_o  (low_len),
        .high_len_o (high_len),
        .gen_ok_o   (gen_ok)
    );

    // Generation runs only when enabled, requested and a high count exists
    always_ff @(posedge clk) begin
        if (!rst_n) running_q <= 1'b0;
        else        running_q <= enable && run && gen_ok;
    end

    scl_prescale #(.CNT_W(CNT_W)) u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (running_q),
        .lim_i  (psc_q),
        .tick_o (tick)
    );

    scl_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (running_q),
        .tick_i     (tick),
        .low_len_i  (low_len),
        .high_len_i (high_len),
        .phase_o    (phase)
    );

    assign scl_level = running_q ? phase : 1'b1;
    assign scl_ce    = tick;

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable || !run) |=> (scl_level && !scl_ce));

    // R2
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(enable)) |->
            ($stable(psc_q) && $stable(low_len) && $stable(high_len)));

    // R7
    no_high_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_ok |-> (scl_level && !scl_ce));

endmodule

// File: tb/test_scl_clk_div.sv
module test_scl_clk_div;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        run = 1'b0;
    logic [15:0] psc_val = '0;
    logic [15:0] low_val = '0;
    logic [15:0] high_val = '0;
    logic        scl_d, ce_d, scl_f, ce_f;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    scl_clk_div i_scl_clk_div (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .psc_val(psc_val), .low_val(low_val), .high_val(high_val),
        .scl_level(scl_d), .scl_ce(ce_d)
    );

    scl_clk_div #(.USE_FIXED_OFFSET(1'b1)) i_scl_clk_div_fixed (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .psc_val(psc_val), .low_val(low_val), .high_val(high_val),
        .scl_level(scl_f), .scl_ce(ce_f)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Offset per the requirements (R4 default, R5 fixed)
    function automatic int exp_ofs(input bit fx, input int psc);
        if (fx) return 6;
        if (psc == 0) return 7;
        if (psc == 1) return 6;
        return 5;
    endfunction

    function automatic logic scl_of(input bit fx);
        return fx ? scl_f : scl_d;
    endfunction

    // Count consecutive falling-edge samples at the given level
    task automatic count_level(input bit fx, input logic lvl, output int n);
        n = 0;
        while (scl_of(fx) == lvl && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic load_idle(input int p, input int lo, input int hi);
        enable = 1'b0; run = 1'b0;
        psc_val = 16'(p); low_val = 16'(lo); high_val = 16'(hi);
        repeat (3) @(negedge clk);
    endtask

    // R6 with R4/R5: two low halves and one high half after a start
    task automatic t_wave(input bit fx, input int p, input int lo, input int hi);
        int n;
        int d = exp_ofs(fx, p);
        string rq = fx ? "R5/R6" : "R4/R6";
        load_idle(p, lo, hi);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        count_level(fx, 1'b0, n);
        chk(n == (lo + d) * (p + 1), rq, n, (lo + d) * (p + 1));
        count_level(fx, 1'b1, n);
        chk(n == (hi + d) * (p + 1), rq, n, (hi + d) * (p + 1));
        count_level(fx, 1'b0, n);
        chk(n == (lo + d) * (p + 1), rq, n, (lo + d) * (p + 1));
        enable = 1'b0; run = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(scl_d == 1'b1, "R1 reset scl", int'(scl_d), 1);
        chk(ce_d == 1'b0, "R1 reset ce", int'(ce_d), 0);
    endtask

    // R1: enabled but no run request keeps SCL released
    task automatic t_no_run();
        int hi_cnt = 0;
        load_idle(2, 3, 3);
        enable = 1'b1;
        repeat (30) begin
            @(negedge clk);
            if (scl_d == 1'b1 && ce_d == 1'b0) hi_cnt++;
        end
        chk(hi_cnt == 30, "R1 run low", hi_cnt, 30);
        enable = 1'b0;
        @(negedge clk);
    endtask

    // R3: tick timing from start and gap between ticks
    task automatic t_tick(input int p);
        int first = 0;
        int gap = 0;
        load_idle(p, 20, 20);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        while (!ce_d && first < 1000) begin first++; @(negedge clk); end
        chk(first == p, "R3 first tick", first, p);
        @(negedge clk);
        gap = 1;
        while (!ce_d && gap < 1000) begin gap++; @(negedge clk); end
        chk(gap == p + 1, "R3 tick gap", gap, p + 1);
        enable = 1'b0; run = 1'b0;
        @(negedge clk);
    endtask

    // R2: fields changed while enabled are ignored until next reset window
    task automatic t_frozen();
        int n;
        load_idle(1, 3, 2);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        psc_val = 16'd4; low_val = 16'd9; high_val = 16'd9;
        count_level(1'b0, 1'b0, n);
        chk(n == 18, "R2 low frozen", n, 18);
        count_level(1'b0, 1'b1, n);
        chk(n == 16, "R2 high frozen", n, 16);
        enable = 1'b0; run = 1'b0;
        repeat (3) @(negedge clk);
        enable = 1'b1; run = 1'b1;
        @(negedge clk);
        count_level(1'b0, 1'b0, n);
        chk(n == 70, "R2 new low", n, 70);
        enable = 1'b0; run = 1'b0;
        @(negedge clk);
    endtask

    // R7: zero high count produces no clock
    task automatic t_zero_high();
        int ok = 0;
        load_idle(0, 4, 0);
        enable = 1'b1; run = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (scl_d && !ce_d && scl_f && !ce_f) ok++;
        end
        chk(ok == 40, "R7 no clock", ok, 40);
        enable = 1'b0; run = 1'b0;
        @(negedge clk);
    endtask

    // R8 and R1: stop mid-phase releases SCL; restart gives a full low half
    task automatic t_restart();
        int n;
        load_idle(0, 10, 10);
        enable = 1'b1; run = 1'b1;
        repeat (6) @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        chk(scl_d == 1'b1 && ce_d == 1'b0, "R1 stop release", int'(scl_d), 1);
        repeat (2) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        count_level(1'b0, 1'b0, n);
        chk(n == 17, "R8 full low after restart", n, 17);
        enable = 1'b0; run = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_run();
        t_wave(1'b0, 0, 3, 2);
        t_wave(1'b0, 1, 4, 1);
        t_wave(1'b0, 2, 0, 5);
        t_wave(1'b0, 5, 2, 2);
        t_wave(1'b1, 0, 3, 2);
        t_wave(1'b1, 3, 1, 4);
        t_tick(0);
        t_tick(3);
        t_frozen();
        t_zero_high();
        t_restart();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule